// File: doc/BRIEF.md
# Condition-Code Flags and Branch Decision Unit

This unit keeps the four arithmetic status flags of a 16-bit processor: negative (N), zero (Z), overflow (V) and carry (C). It recognises the flag-operate instructions. One such word can set or clear any chosen subset of the four flags at once. For any conditional branch word presented with a valid strobe, it reports in the same cycle whether that branch is taken under the current flags.

The flags can change in three ways. A write to the status word on the system bus loads all four. A flag-operate instruction sets or clears masked flags. The ALU can update individual flags through a per-flag write enable. The flags appear on `flags_o` with N in bit 3, Z in bit 2, V in bit 1 and C in bit 0, which is also their layout in the low nibble of the status word. The branch target, instruction fetch and the upper status word fields are handled elsewhere.

Top module: `cc_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first update, `flags_o` is 4'b0000 and `br_taken_o` is 0 when no valid word is presented.
- R2: A valid word with bits [15:5] equal to 11'b00000000101 and bit 4 equal to 0 is a clear operate: after the next clock edge, each flag whose mask bit (bits 3..0 in N,Z,V,C order) is 1 is 0, and every other flag keeps its value.
- R3: The same pattern with bit 4 equal to 1 is a set operate: masked flags become 1 after the next edge, and unmasked flags are unchanged.
- R4: One operate word acts on all of its masked flags together. Mask 4'b1111 clears or sets all four flags. A set with N and Z both masked stores and reports N=1 and Z=1 together.
- R5: When `bus_we_i` is 1, `bus_wdata_i` (N bit 3, Z bit 2, V bit 1, C bit 0) is loaded into the flags at the next edge. A write of zero clears all flags.
- R6: With no bus write and no operate, each flag whose `alu_we_i` bit is 1 takes the matching `alu_flags_i` bit at the next edge, and each flag whose enable is 0 holds its value.
- R7: The sources rank in a fixed order: a bus write beats an operate, and an operate beats an ALU update, in the same cycle.
- R8: Words presented with `instr_vld_i` low change no flag and give `br_taken_o` 0. With no source active, the flags hold.
- R9: `br_taken_o` is combinational from the valid word and the current flags. It looks at the high byte {bit 15, bits 14..8}. Bits 14..11 must be 0. The group code {bit15, bit10, bit9} selects a condition: 000 always, 001 Z, 010 N^V, 011 Z|(N^V), 100 N, 101 C|Z, 110 V, 111 C. The branch is taken when the condition equals bit 8. For group 000, only bit 8 = 1 (branch always) is a branch.
- R10: High byte 8'h86 (branch on carry clear) is taken exactly when C=0. High byte 8'h87 (branch on carry set) is taken exactly when C=1.
- R11: Words that are not branches, meaning bits 14..11 are nonzero or the high byte is 8'h00, give `br_taken_o` 0 whatever the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word under decode |
| instr_vld_i | input | 1 | Instruction word is valid this cycle |
| bus_we_i | input | 1 | Bus write to the status word |
| bus_wdata_i | input | 4 | Low nibble of the status word being written |
| alu_we_i | input | 4 | Per-flag ALU update enable (N,Z,V,C) |
| alu_flags_i | input | 4 | Flag values from the ALU (N,Z,V,C) |
| flags_o | output | 4 | Current flags (N,Z,V,C) |
| br_taken_o | output | 1 | Branch condition met for the valid word |

## Verification
`br_taken_o` depends only on the current inputs and the registered flags, so it is due in the cycle the word is driven. The bench samples it a short delay after driving, well before the next rising edge. Every flag change (bus load, operate, ALU update) shows on `flags_o` one edge after the stimulus, so the bench moves its reference model forward at that edge and compares on the following falling edge. Random words, with directed corner cases mixed in, are checked this way cycle by cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int INSTR_W = 16;
  localparam int FLAG_W  = 4;
  localparam int OP_W    = 8;
  localparam int MASK_W  = FLAG_W;
  // operate prefix, instr[15:5]
  localparam int PFX_W   = INSTR_W - MASK_W - 1;
  localparam logic [PFX_W-1:0] CCOP_PFX = 11'b00000000101;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  typedef enum logic [2:0] {
    GRP_ALW = 3'b000,
    GRP_Z   = 3'b001,
    GRP_NXV = 3'b010,
    GRP_ZNV = 3'b011,
    GRP_N   = 3'b100,
    GRP_CZ  = 3'b101,
    GRP_V   = 3'b110,
    GRP_C   = 3'b111
  } br_grp_e;
endpackage

// File: rtl/cc_decode.sv
module cc_decode
  import cc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               vld_i,
  output logic               op_vld_o,
  output logic               op_set_o,
  output logic [MASK_W-1:0]  op_mask_o
);
  logic [PFX_W-1:0] pfx;
  assign pfx       = instr_i[INSTR_W-1 -: PFX_W];
  assign op_vld_o  = vld_i && (pfx == CCOP_PFX);
  assign op_set_o  = instr_i[MASK_W];
  assign op_mask_o = instr_i[MASK_W-1:0];
endmodule

// File: rtl/cc_br_eval.sv
module cc_br_eval
  import cc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic            vld_i,
  input  cc_t             cc_i,
  output logic            taken_o
);
  br_grp_e grp;
  logic    sense;
  logic    base;
  logic    is_br;

  assign grp   = br_grp_e'({op_i[7], op_i[2:1]});
  assign sense = op_i[0];
  // group 000 with sense 0 is not a branch
  assign is_br = (op_i[6:3] == 4'b0000) && !(grp == GRP_ALW && !sense);

  always_comb begin
    unique case (grp)
      GRP_ALW: base = 1'b1;
      GRP_Z:   base = cc_i.z;
      GRP_NXV: base = cc_i.n ^ cc_i.v;
      GRP_ZNV: base = cc_i.z | (cc_i.n ^ cc_i.v);
      GRP_N:   base = cc_i.n;
      GRP_CZ:  base = cc_i.c | cc_i.z;
      GRP_V:   base = cc_i.v;
      GRP_C:   base = cc_i.c;
      default: base = 1'b0;
    endcase
  end

  assign taken_o = vld_i && is_br && (base == sense);

  // R10
  bcc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && op_i == 8'h86) |-> (taken_o == !cc_i.c));
  // R10
  bcs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && op_i == 8'h87) |-> (taken_o == cc_i.c));
  // R11
  nonbr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[6:3] != 4'b0000 || op_i == 8'h00) |-> !taken_o);
  // R8
  novld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |-> !taken_o);
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [FLAG_W-1:0] bus_wdata_i,
  input  logic              op_vld_i,
  input  logic              op_set_i,
  input  logic [MASK_W-1:0] op_mask_i,
  input  logic [FLAG_W-1:0] alu_we_i,
  input  logic [FLAG_W-1:0] alu_flags_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_d;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    always_comb begin
      if (bus_we_i)          flags_d[i] = bus_wdata_i[i];
      else if (op_vld_i)     flags_d[i] = op_mask_i[i] ? op_set_i : flags_q[i];
      else if (alu_we_i[i])  flags_d[i] = alu_flags_i[i];
      else                   flags_d[i] = flags_q[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[i] <= 1'b0;
      else         flags_q[i] <= flags_d[i];
    end
  end

  assign flags_o = flags_q;

  // R5
  bus_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i |=> (flags_o == $past(bus_wdata_i)));
  // R3
  set_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i && op_vld_i && op_set_i) |=>
      ((flags_o & $past(op_mask_i)) == $past(op_mask_i)));
  // R2
  clr_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i && op_vld_i && !op_set_i) |=>
      ((flags_o & $past(op_mask_i)) == '0));
  // R2
  op_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i && op_vld_i) |=>
      ((flags_o & ~$past(op_mask_i)) == ($past(flags_o) & ~$past(op_mask_i))));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i && !op_vld_i && alu_we_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/cc_unit.sv
module cc_unit
  import cc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               instr_vld_i,
  input  logic               bus_we_i,
  input  logic [FLAG_W-1:0]  bus_wdata_i,
  input  logic [FLAG_W-1:0]  alu_we_i,
  input  logic [FLAG_W-1:0]  alu_flags_i,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               br_taken_o
);
  logic              op_vld;
  logic              op_set;
  logic [MASK_W-1:0] op_mask;
  logic [FLAG_W-1:0] flags;

  cc_decode u_dec (
    .instr_i   (instr_i),
    .vld_i     (instr_vld_i),
    .op_vld_o  (op_vld),
    .op_set_o  (op_set),
    .op_mask_o (op_mask)
  );

  cc_flag_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .op_vld_i    (op_vld),
    .op_set_i    (op_set),
    .op_mask_i   (op_mask),
    .alu_we_i    (alu_we_i),
    .alu_flags_i (alu_flags_i),
    .flags_o     (flags)
  );

  cc_br_eval u_br (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (instr_i[INSTR_W-1 -: OP_W]),
    .vld_i   (instr_vld_i),
    .cc_i    (cc_t'(flags)),
    .taken_o (br_taken_o)
  );

  assign flags_o = flags;

  // R7
  bus_over_alu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && alu_we_i != '0) |=> (flags_o == $past(bus_wdata_i)));
endmodule

// File: tb/tb_cc_unit.sv
module tb_cc_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr = '0;
  logic        vld = 1'b0;
  logic        bwe = 1'b0;
  logic [3:0]  bdat = '0;
  logic [3:0]  awe = '0;
  logic [3:0]  adat = '0;
  logic [3:0]  flags;
  logic        taken;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic [3:0] exp_f = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_unit dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .instr_i     (instr),
    .instr_vld_i (vld),
    .bus_we_i    (bwe),
    .bus_wdata_i (bdat),
    .alu_we_i    (awe),
    .alu_flags_i (adat),
    .flags_o     (flags),
    .br_taken_o  (taken)
  );

  function automatic logic ref_br(input logic [7:0] op, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (op)
      8'h01: return 1'b1;
      8'h02: return !z;
      8'h03: return z;
      8'h04: return !(n ^ v);
      8'h05: return n ^ v;
      8'h06: return !(z || (n ^ v));
      8'h07: return z || (n ^ v);
      8'h80: return !n;
      8'h81: return n;
      8'h82: return !(c || z);
      8'h83: return c || z;
      8'h84: return !v;
      8'h85: return v;
      8'h86: return !c;
      8'h87: return c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_op(input logic [15:0] w);
    return (w & 16'hFFE0) == 16'h00A0;
  endfunction

  function automatic logic [3:0] ref_next(input logic [3:0] f, input logic [15:0] w,
      input logic v, input logic be, input logic [3:0] bd,
      input logic [3:0] ae, input logic [3:0] ad);
    if (be) return bd;
    if (v && is_op(w)) return w[4] ? (f | w[3:0]) : (f & ~w[3:0]);
    return (f & ~ae) | (ad & ae);
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, expv, $time);
    end
  endtask

  // called at a falling edge: drive, check branch, clock, check flags
  task automatic step(input logic [15:0] w, input logic v, input logic be,
      input logic [3:0] bd, input logic [3:0] ae, input logic [3:0] ad);
    string btag, ftag;
    logic eb;
    instr = w; vld = v; bwe = be; bdat = bd; awe = ae; adat = ad;
    #1;
    eb = v && ref_br(w[15:8], exp_f);
    if (w[15:8] == 8'h86 || w[15:8] == 8'h87) btag = "R10";
    else if (!v) btag = "R8";
    else if (w[14:11] != 4'b0000 || w[15:8] == 8'h00) btag = "R11";
    else btag = "R9";
    check(btag, {3'b000, taken}, {3'b000, eb});
    if (be && ((v && is_op(w)) || ae != 0)) ftag = "R7";
    else if (be) ftag = "R5";
    else if (v && is_op(w) && ae != 0) ftag = "R7";
    else if (v && is_op(w) && w[3:0] == 4'hF) ftag = "R4";
    else if (v && is_op(w)) ftag = w[4] ? "R3" : "R2";
    else if (ae != 0) ftag = "R6";
    else ftag = "R8";
    @(posedge clk);
    exp_f = ref_next(exp_f, w, v, be, bd, ae, ad);
    @(negedge clk);
    check(ftag, flags, exp_f);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", flags, 4'b0000);
    check("R1", {3'b000, taken}, 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", flags, 4'b0000);

    // directed corner cases
    step(16'h00BF, 1, 0, 0, 0, 0);            // R4 set all
    check("R4", flags, 4'b1111);
    step(16'h00AF, 1, 0, 0, 0, 0);            // R4 clear all
    check("R4", flags, 4'b0000);
    step(16'h00BC, 1, 0, 0, 0, 0);            // R4 N and Z together
    check("R4", flags, 4'b1100);
    step(16'h0312, 1, 0, 0, 0, 0);            // R9 BEQ taken
    step(16'h8134, 1, 0, 0, 0, 0);            // R9 BMI taken
    step(16'h0620, 1, 0, 0, 0, 0);            // R9 BGT not taken
    step(16'h00BF, 1, 0, 0, 0, 0);
    step(16'h00A9, 1, 0, 0, 0, 0);            // R2 clear N and C
    check("R2", flags, 4'b0110);
    step(16'h8601, 1, 0, 0, 0, 0);            // R10 BCC, C=0
    step(16'h8701, 1, 0, 0, 0, 0);            // R10 BCS, C=0
    step(16'h00B1, 1, 0, 0, 0, 0);            // R3 set C
    check("R3", flags, 4'b0111);
    step(16'h8601, 1, 0, 0, 0, 0);            // R10
    step(16'h8701, 1, 0, 0, 0, 0);            // R10
    step(16'h00BF, 1, 1, 4'b0101, 4'hF, 4'h0); // R7 bus wins
    check("R7", flags, 4'b0101);
    step(16'h00B8, 1, 0, 0, 4'hF, 4'h0);     // R7 operate beats ALU
    check("R7", flags, 4'b1101);
    step(16'h00BF, 0, 0, 0, 0, 0);            // R8 invalid operate ignored
    check("R8", flags, 4'b1101);
    step(16'h0100, 0, 0, 0, 0, 0);            // R8 invalid BR
    step(16'h0100, 1, 0, 0, 0, 0);            // R9 BR
    step(16'h0000, 1, 0, 0, 0, 0);            // R11
    step(16'h4100, 1, 0, 0, 0, 0);            // R11
    step(16'h0000, 0, 1, 4'b0000, 0, 0);      // R5 bus zero clears
    check("R5", flags, 4'b0000);
    step(16'h0000, 0, 0, 0, 4'b0101, 4'b1111); // R6 partial ALU
    check("R6", flags, 4'b0101);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      int k;
      k = $urandom_range(0, 2);
      if (k == 0) w = {11'b00000000101, 5'($urandom)};
      else if (k == 1) w = {1'($urandom), 4'b0000, 3'($urandom), 8'($urandom)};
      else w = 16'($urandom);
      step(w, $urandom_range(0, 9) < 8,
           $urandom_range(0, 9) == 0, 4'($urandom),
           ($urandom_range(0, 9) < 3) ? 4'($urandom) : 4'h0, 4'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule